// File: doc/BRIEF.md
# Low-Power Interrupt Capture Controller

This block sits between a set of external interrupt lines and a main interrupt controller that may be powered down. Software configures each line before the main controller loses power. The block then records qualifying edges into per-line status bits while it is enabled in edge-recording mode. After power returns, software writes a flush command. Every line with a recorded edge then sends exactly one single-cycle pulse toward the parent controller, so no interrupt is lost across the power-down.

Software uses a simple word-addressed register bus. Mask, sensitivity and polarity each have a write-one-to-set word and a write-one-to-clear word. The bus also reaches a write-one acknowledge word, a read-only status word and one control word. A parameter selects one of two address layouts. Line n lives in bit n mod 32 of word n div 32 of each per-line function.

Top module: `lpic_top`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0 and `line_pulse` is 0. This leaves the block disabled, with every line unmasked and level-sensitive.
- R2: Writing 1 to a bit of a set word sets that line's attribute, and writing 1 to a bit of the matching clear word clears it. Writing 0 leaves the attribute unchanged. A read at either the set or the clear offset returns the current attribute word.
- R3: Line n is addressed by bit (n mod 32) of the word at the function base + 4*(n div 32). For example, line 37 is bit 5 of the second word.
- R4: A line's status bit is set only when all of these hold: control bit 0 (enable) is 1, control bit 1 (edge recording) is 1, the line's sensitivity bit is 1 (edge), and its mask bit is 0. The line must also see an edge of its polarity: polarity 1 selects rising and 0 selects falling.
- R5: The status word reads the recorded bits. Writing 1 to an acknowledge bit clears that line's recorded bit, and acknowledge words read as 0.
- R6: A control write with bit 2 set drives `line_pulse` high for exactly one cycle on each line whose status was set. The pulse starts in the cycle after the write, and those status bits clear.
- R7: Control bits 0 and 1 read back as last written. Bit 2 is self-clearing and always reads 0.
- R8: An edge that qualifies in the same cycle as a flush write is kept in status and is replayed by the next flush.
- R9: With LAYOUT=1 the offsets are status 0x0, ack 0x40, mask set/clear 0xC0/0x100, sensitivity set/clear 0x180/0x1C0, polarity set/clear 0x240/0x280, control 0x300. With LAYOUT=2 they are 0x0, 0x80, 0x180/0x200, 0x300/0x380, 0x480/0x500, 0x600.
- R10: A read of any unmapped offset returns 0. Read data appears on `bus_rdata` in the cycle after `bus_rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe for one cycle |
| bus_rd_en | input | 1 | Read strobe; data follows one cycle later |
| bus_addr | input | ADDR_W | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| line_in | input | NUM_LINES | Interrupt lines, already synchronous to clk |
| line_pulse | output | NUM_LINES | One-cycle replay pulses toward the parent controller |

## Verification
The bench checks the qualification rule one condition at a time, using lines in a single word: a masked line, a level-sensitive line, a falling-polarity line and a line in the second word. A design that decoded the polarity backwards, or that ignored the mask, would report the wrong status bits. A scoreboard expects exactly one pulse vector per flush and no pulse on an empty flush. It therefore catches a pulse that lasts two cycles, a flush that reads back as set, and an edge dropped because it coincided with the flush. The second layout is checked through its own offsets to catch a decoder hard-wired to the first layout.

// File: rtl/lpic_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the interrupt capture controller: register
// function codes, control bit positions and the two address layouts.
package lpic_pkg;

    typedef enum logic [3:0] {
        FN_STATUS, FN_ACK, FN_MSET, FN_MCLR, FN_SSET,
        FN_SCLR, FN_PSET, FN_PCLR, FN_CTRL
    } lpic_fn_e;

    localparam int NUM_FN        = 9;
    localparam int CTL_EN_BIT    = 0;
    localparam int CTL_EDGE_BIT  = 1;
    localparam int CTL_FLUSH_BIT = 2;

    // Byte offset of each register function for the selected layout.
    function automatic logic [31:0] fn_base(input int layout, input lpic_fn_e fn);
        logic [31:0] b;
        if (layout == 2) begin
            case (fn)
                FN_ACK:  b = 32'h080;
                FN_MSET: b = 32'h180;
                FN_MCLR: b = 32'h200;
                FN_SSET: b = 32'h300;
                FN_SCLR: b = 32'h380;
                FN_PSET: b = 32'h480;
                FN_PCLR: b = 32'h500;
                FN_CTRL: b = 32'h600;
                default: b = 32'h000;
            endcase
        end else begin
            case (fn)
                FN_ACK:  b = 32'h040;
                FN_MSET: b = 32'h0C0;
                FN_MCLR: b = 32'h100;
                FN_SSET: b = 32'h180;
                FN_SCLR: b = 32'h1C0;
                FN_PSET: b = 32'h240;
                FN_PCLR: b = 32'h280;
                FN_CTRL: b = 32'h300;
                default: b = 32'h000;
            endcase
        end
        return b;
    endfunction

endpackage

// File: rtl/lpic_regs.sv
`timescale 1ns/1ps
// Register file and address decoder.
// Holds the mask, sensitivity, polarity and control state. It turns bus
// writes into set/clear updates, acknowledge vectors and a flush strobe.
// Assumes word-aligned byte addresses; misaligned or unmapped accesses
// decode to nothing and read as 0.
module lpic_regs
    import lpic_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int LAYOUT    = 1,
    parameter int ADDR_W    = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [31:0]          wdata,
    input  logic [NUM_LINES-1:0] status,
    output logic [31:0]          rdata,
    output logic [NUM_LINES-1:0] mask,
    output logic [NUM_LINES-1:0] sens,
    output logic [NUM_LINES-1:0] pol,
    output logic                 ctrl_en,
    output logic                 ctrl_edge,
    output logic                 flush_req,
    output logic [NUM_LINES-1:0] ack_vec
);
    localparam int NWORDS = (NUM_LINES + 31) / 32;
    localparam int FW     = NWORDS * 32;

    logic [31:0]       addr32;
    logic [NUM_FN-1:0] hit;
    logic [31:0]       widx [NUM_FN];
    logic [FW-1:0]     wv   [NUM_FN];
    logic [31:0]       rd_next;

    assign addr32 = 32'(addr);

    // One decoder per register function; per-line functions span NWORDS words.
    for (genvar g = 0; g < NUM_FN; g++) begin : g_dec
        localparam logic [31:0] BASE = fn_base(LAYOUT, lpic_fn_e'(g));
        localparam int          SPAN = (g == int'(FN_CTRL)) ? 1 : NWORDS;
        assign hit[g]  = (addr32 >= BASE) && (addr32 < BASE + 32'(SPAN * 4))
                         && (addr[1:0] == 2'b00);
        assign widx[g] = (addr32 - BASE) >> 2;
        assign wv[g]   = (wr_en && hit[g]) ? (FW'(wdata) << (32 * widx[g])) : '0;
    end

    // Extract one 32-bit word from a padded per-line vector.
    function automatic logic [31:0] pick(input logic [FW-1:0] v, input logic [31:0] idx);
        return 32'(v >> (32 * idx));
    endfunction

    assign ack_vec   = wv[FN_ACK][NUM_LINES-1:0];
    assign flush_req = wr_en && hit[FN_CTRL] && wdata[CTL_FLUSH_BIT];

    // Read multiplexer: attribute words read at either set or clear offset.
    always_comb begin
        rd_next = '0;
        if (hit[FN_STATUS]) rd_next = pick(FW'(status), widx[FN_STATUS]);
        if (hit[FN_MSET])   rd_next = pick(FW'(mask),   widx[FN_MSET]);
        if (hit[FN_MCLR])   rd_next = pick(FW'(mask),   widx[FN_MCLR]);
        if (hit[FN_SSET])   rd_next = pick(FW'(sens),   widx[FN_SSET]);
        if (hit[FN_SCLR])   rd_next = pick(FW'(sens),   widx[FN_SCLR]);
        if (hit[FN_PSET])   rd_next = pick(FW'(pol),    widx[FN_PSET]);
        if (hit[FN_PCLR])   rd_next = pick(FW'(pol),    widx[FN_PCLR]);
        if (hit[FN_CTRL])   rd_next = {30'd0, ctrl_edge, ctrl_en};
    end

    // Registered read data, updated only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_next;
    end

    // Write-one set/clear updates of the per-line attributes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
            sens <= '0;
            pol  <= '0;
        end else begin
            mask <= (mask | wv[FN_MSET][NUM_LINES-1:0]) & ~wv[FN_MCLR][NUM_LINES-1:0];
            sens <= (sens | wv[FN_SSET][NUM_LINES-1:0]) & ~wv[FN_SCLR][NUM_LINES-1:0];
            pol  <= (pol  | wv[FN_PSET][NUM_LINES-1:0]) & ~wv[FN_PCLR][NUM_LINES-1:0];
        end
    end

    // Control word: enable and edge bits are stored, flush is a strobe only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en   <= 1'b0;
            ctrl_edge <= 1'b0;
        end else if (wr_en && hit[FN_CTRL]) begin
            ctrl_en   <= wdata[CTL_EN_BIT];
            ctrl_edge <= wdata[CTL_EDGE_BIT];
        end
    end

endmodule

// File: rtl/lpic_capture.sv
`timescale 1ns/1ps
// Per-line edge recorder and replay stage.
// Detects edges of the configured polarity, records qualifying ones and
// replays the record as a one-cycle pulse on flush. Inputs are assumed
// synchronous to clk. A qualifying edge wins over a flush or acknowledge
// in the same cycle, so it stays recorded.
module lpic_capture #(
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_in,
    input  logic [NUM_LINES-1:0] mask,
    input  logic [NUM_LINES-1:0] sens,
    input  logic [NUM_LINES-1:0] pol,
    input  logic                 ctrl_en,
    input  logic                 ctrl_edge,
    input  logic                 flush_req,
    input  logic [NUM_LINES-1:0] ack_vec,
    output logic [NUM_LINES-1:0] status,
    output logic [NUM_LINES-1:0] pulse
);
    logic recording;
    assign recording = ctrl_en && ctrl_edge;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic prev_q;
        logic edge_seen;
        logic qualify;

        assign edge_seen = pol[i] ? (line_in[i] && !prev_q) : (!line_in[i] && prev_q);
        assign qualify   = recording && sens[i] && !mask[i] && edge_seen;

        // Remember the last input level for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= line_in[i];
        end

        // Record, acknowledge and flush-clear the line's status bit.
        always_ff @(posedge clk) begin
            if (!rst_n) status[i] <= 1'b0;
            else        status[i] <= ((flush_req || ack_vec[i]) ? 1'b0 : status[i]) | qualify;
        end

        // Emit one replay pulse for a recorded line on flush.
        always_ff @(posedge clk) begin
            if (!rst_n) pulse[i] <= 1'b0;
            else        pulse[i] <= flush_req && status[i];
        end
    end

endmodule

// File: rtl/lpic_top.sv
`timescale 1ns/1ps
// Low-power interrupt capture controller, top level.
// Joins the register file to the edge recorder. LAYOUT selects one of
// two address maps; NUM_LINES must fit the 32-line-per-word spacing of
// the chosen map.
module lpic_top #(
    parameter int NUM_LINES = 64,
    parameter int LAYOUT    = 1,
    parameter int ADDR_W    = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr_en,
    input  logic                 bus_rd_en,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_LINES-1:0] line_in,
    output logic [NUM_LINES-1:0] line_pulse
);
    logic [NUM_LINES-1:0] status_w, mask_w, sens_w, pol_w, ack_w;
    logic                 en_w, edge_w, flush_w;

    lpic_regs #(.NUM_LINES(NUM_LINES), .LAYOUT(LAYOUT), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .rd_en(bus_rd_en),
        .addr(bus_addr), .wdata(bus_wdata), .status(status_w), .rdata(bus_rdata),
        .mask(mask_w), .sens(sens_w), .pol(pol_w), .ctrl_en(en_w),
        .ctrl_edge(edge_w), .flush_req(flush_w), .ack_vec(ack_w)
    );

    lpic_capture #(.NUM_LINES(NUM_LINES)) u_cap (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .mask(mask_w), .sens(sens_w),
        .pol(pol_w), .ctrl_en(en_w), .ctrl_edge(edge_w), .flush_req(flush_w),
        .ack_vec(ack_w), .status(status_w), .pulse(line_pulse)
    );

endmodule

// File: rtl/lpic_chk.sv
`timescale 1ns/1ps
// Property checker for lpic_top, attached by bind. It observes the
// pulse output and the status, mask and control state.
module lpic_chk #(
    parameter int NUM_LINES = 64
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] line_pulse,
    input logic [NUM_LINES-1:0] status,
    input logic [NUM_LINES-1:0] mask,
    input logic                 ctrl_en,
    input logic                 ctrl_edge,
    input logic                 flush_req
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (line_pulse == '0 && status == '0 && !ctrl_en && !ctrl_edge));

    // R6
    pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |=> (line_pulse == $past(status)));

    // R6
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_pulse != '0) |-> $past(flush_req));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl_en && ctrl_edge) |=> ((status & ~$past(status)) == '0));

    // R4
    masked_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~$past(status) & $past(mask)) == '0));

endmodule

bind lpic_top lpic_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk(clk), .rst_n(rst_n), .line_pulse(line_pulse), .status(status_w),
    .mask(mask_w), .ctrl_en(en_w), .ctrl_edge(edge_w), .flush_req(flush_w)
);

// File: tb/tb_lpic_top.sv
`timescale 1ns/1ps
// Scoreboard bench: flush stimulus pushes expected pulse vectors, a
// monitor pops and compares them whenever the design emits a pulse.
module tb_lpic_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [63:0] line_in = '0;
    logic [63:0] line_pulse;
    logic        wr2 = 1'b0, rd2 = 1'b0;
    logic [11:0] addr2 = '0;
    logic [31:0] wdata2 = '0;
    logic [31:0] rdata2;
    logic [63:0] line_in2 = '0;
    logic [63:0] line_pulse2;

    int nchk = 0;
    int nfail = 0;
    logic [63:0] exp_q[$];

    always #5 clk = ~clk;

    lpic_top #(.NUM_LINES(64), .LAYOUT(1), .ADDR_W(12)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(wr_en), .bus_rd_en(rd_en),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
        .line_in(line_in), .line_pulse(line_pulse));

    lpic_top #(.NUM_LINES(64), .LAYOUT(2), .ADDR_W(12)) dut_l2 (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(wr2), .bus_rd_en(rd2),
        .bus_addr(addr2), .bus_wdata(wdata2), .bus_rdata(rdata2),
        .line_in(line_in2), .line_pulse(line_pulse2));

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic bus_wr(input bit u2, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        if (u2) begin wr2 = 1'b1; addr2 = a; wdata2 = d; end
        else    begin wr_en = 1'b1; addr = a; wdata = d; end
        @(negedge clk);
        wr2 = 1'b0; wr_en = 1'b0;
    endtask

    task automatic bus_rd(input bit u2, input logic [11:0] a, input logic [31:0] exp,
                          input string req);
        @(negedge clk);
        if (u2) begin rd2 = 1'b1; addr2 = a; end
        else    begin rd_en = 1'b1; addr = a; end
        @(negedge clk);
        rd2 = 1'b0; rd_en = 1'b0;
        check(req, 64'(u2 ? rdata2 : rdata), 64'(exp));
    endtask

    task automatic pulse_lines(input logic [63:0] m);
        @(negedge clk); line_in = line_in | m;
        @(negedge clk); line_in = line_in & ~m;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    endtask

    // Monitor: every nonzero pulse vector must match the next expected flush.
    always @(negedge clk) begin
        if (rst_n && line_pulse != '0) begin
            if (exp_q.size() == 0) begin
                nchk++; nfail++;
                $display("FAIL R6 unexpected pulse got=%h exp=0", line_pulse);
            end else begin
                check("R6 flush pulse", line_pulse, exp_q.pop_front());
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog got=timeout exp=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 pulse in reset", line_pulse, '0);
        rst_n = 1'b1;
        // R1 reset state
        bus_rd(0, 12'h300, 32'h0, "R1 control after reset");
        bus_rd(0, 12'h0C0, 32'h0, "R1 mask after reset");
        bus_rd(0, 12'h000, 32'h0, "R1 status after reset");
        // R2 write-one set and clear
        bus_wr(0, 12'h0C0, 32'h0000_00F0);
        bus_wr(0, 12'h100, 32'h0000_0030);
        bus_rd(0, 12'h0C0, 32'h0000_00C0, "R2 mask at set offset");
        bus_rd(0, 12'h100, 32'h0000_00C0, "R2 mask at clear offset");
        // R3 line 37 -> word 1 bit 5
        bus_wr(0, 12'h184, 32'h0000_0020);
        bus_rd(0, 12'h184, 32'h0000_0020, "R3 sense word 1");
        bus_rd(0, 12'h180, 32'h0000_0000, "R3 sense word 0 untouched");
        // R7 control read-modify-write
        bus_wr(0, 12'h300, 32'h3);
        bus_rd(0, 12'h300, 32'h3, "R7 control readback");
        // R4 configuration: lines 0..3 edge, 0/2 rising, 1/3 falling, 3 masked, 4 level
        bus_wr(0, 12'h180, 32'h0000_000F);
        bus_wr(0, 12'h240, 32'h0000_0005);
        bus_wr(0, 12'h244, 32'h0000_0020);
        bus_wr(0, 12'h0C0, 32'h0000_0008);
        pulse_lines(64'h0000_0020_0000_001F);
        bus_rd(0, 12'h000, 32'h0000_0007, "R4 qualified edges word 0");
        bus_rd(0, 12'h004, 32'h0000_0020, "R3 status of line 37");
        // R5 acknowledge
        bus_wr(0, 12'h040, 32'h0000_0004);
        bus_rd(0, 12'h000, 32'h0000_0003, "R5 ack clears line 2");
        bus_rd(0, 12'h040, 32'h0, "R5 ack reads 0");
        // R6 flush replay
        exp_q.push_back(64'h0000_0020_0000_0003);
        bus_wr(0, 12'h300, 32'h7);
        bus_rd(0, 12'h300, 32'h3, "R7 flush bit self-clears");
        bus_rd(0, 12'h000, 32'h0, "R6 status cleared word 0");
        bus_rd(0, 12'h004, 32'h0, "R6 status cleared word 1");
        // R4 edge mode off: nothing recorded
        bus_wr(0, 12'h300, 32'h1);
        pulse_lines(64'h1);
        bus_rd(0, 12'h000, 32'h0, "R4 no record without edge mode");
        // R6 empty flush produces no pulse
        bus_wr(0, 12'h300, 32'h5);
        repeat (3) @(negedge clk);
        // R8 edge coinciding with flush
        bus_wr(0, 12'h300, 32'h3);
        pulse_lines(64'h4);
        exp_q.push_back(64'h4);
        @(negedge clk);
        line_in[0] = 1'b1;
        wr_en = 1'b1; addr = 12'h300; wdata = 32'h7;
        @(negedge clk);
        wr_en = 1'b0;
        bus_rd(0, 12'h000, 32'h1, "R8 coincident edge kept");
        line_in[0] = 1'b0;
        exp_q.push_back(64'h1);
        bus_wr(0, 12'h300, 32'h7);
        repeat (2) @(negedge clk);
        // R10 unmapped offsets
        bus_rd(0, 12'h3FC, 32'h0, "R10 unmapped read");
        bus_rd(0, 12'h302, 32'h0, "R10 misaligned read");
        // R9 second layout
        bus_wr(1, 12'h180, 32'h0000_0011);
        bus_wr(1, 12'h200, 32'h0000_0001);
        bus_rd(1, 12'h180, 32'h0000_0010, "R9 layout 2 mask");
        bus_wr(1, 12'h300, 32'h1);
        bus_wr(1, 12'h480, 32'h1);
        bus_wr(1, 12'h600, 32'h3);
        bus_rd(1, 12'h600, 32'h3, "R9 layout 2 control");
        @(negedge clk); line_in2[0] = 1'b1;
        @(negedge clk); line_in2[0] = 1'b0;
        bus_rd(1, 12'h000, 32'h1, "R9 layout 2 status");
        bus_wr(1, 12'h600, 32'h7);
        check("R9 layout 2 flush pulse", line_pulse2, 64'h1);
        @(negedge clk);
        check("R6 pulse lasts one cycle", line_pulse2, 64'h0);
        // R6 all expected pulses seen
        check("R6 scoreboard drained", 64'(exp_q.size()), 64'h0);
        finish_run();
    end

endmodule